// File: doc/BRIEF.md
# Power-Fail Early Warning Pulser

This block warns a processor that power is about to fail. An external comparator watches a sense voltage taken upstream of the local regulator. The comparator gives a synchronous flag that is high while that voltage is below its threshold. A second flag shows that the local supply is above its own trip point. Both flags pass through two-flop synchronizers. The block then waits until the sense-low condition has held for a set number of clock cycles. After that it drives a single active-low non-maskable interrupt pulse of fixed width.

The output is a one-shot pulse, not a level. Each falling event of the sense voltage gives exactly one pulse. The sense condition must then clear and stay clear for the same filter time before the block can fire again. While the local supply is still below its trip point, as during power-up, sense-low indications are not counted. The filter time `FILT_CYC` and the pulse width `PULSE_CYC` are parameters in clock cycles. Their defaults, 5 and 200, give the usual microsecond figures at a 1 MHz clock. The block has no data stream, so every pin is a plain control signal.

Top module: `pfw_pulser`

## Requirements
- R1: While `rst_ni` is low, `nmi_no` is high. An asynchronous reset applied during a pulse drives `nmi_no` high at once.
- R2: A pulse fires only after `sense_low_i` (1 = sense voltage below threshold) has been high for at least `FILT_CYC` consecutive clock edges. A high run of `FILT_CYC-1` or fewer edges produces no pulse.
- R3: The input is first sampled high at edge 1. With a qualifying run, `nmi_no` goes low right after edge `FILT_CYC+3`: two synchronizer stages, `FILT_CYC` counting edges, and one trigger register.
- R4: Each pulse holds `nmi_no` low for exactly `PULSE_CYC` clock cycles and then returns it high.
- R5: A sense-low condition that stays high indefinitely produces exactly one pulse.
- R6: After a pulse, the block re-arms only once `sense_low_i` has been low for `FILT_CYC` consecutive edges. A low gap of `FILT_CYC-1` edges followed by a new high run produces no pulse.
- R7: While `vcc_ok_i` (1 = local supply above its trip point) is low, sense-low indications are ignored and no pulse starts. The first sampled edge of a rise of `vcc_ok_i` counts as edge 1. If `sense_low_i` is already high at that rise, `nmi_no` falls right after edge `FILT_CYC+3`.
- R8: If `vcc_ok_i` falls while a pulse is in progress, the pulse still lasts its full `PULSE_CYC` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sense_low_i | input | 1 | Comparator flag, 1 = upstream sense voltage below threshold |
| vcc_ok_i | input | 1 | 1 = local supply above its trip point |
| nmi_no | output | 1 | Active-low non-maskable interrupt pulse |

## Verification
The first flop that samples a change counts as edge 1. A pulse's falling edge is due right after edge `FILT_CYC+3`, and its rising edge comes exactly `PULSE_CYC` cycles later. A suppressed or filtered event must keep `nmi_no` high for the whole observation window. The bench drives inputs on falling clock edges and samples `nmi_no` on every falling edge. In each window it records the index of the first low sample, the number of low samples and the number of falling transitions. It compares these counts with figures computed from the two parameters.

// File: rtl/pfw_pkg.sv
package pfw_pkg;
  typedef enum logic {
    ST_ARMED = 1'b0,
    ST_SPENT = 1'b1
  } arm_e;
endpackage

// File: rtl/pfw_sync.sv
module pfw_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pfw_qualifier.sv
module pfw_qualifier
  import pfw_pkg::*;
#(
  parameter int FILT_CYC = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sense_s_i,
  input  logic vcc_ok_s_i,
  output logic fire_o
);
  localparam int CW = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  arm_e          st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_ARMED;
      cnt_q  <= '0;
      fire_o <= 1'b0;
    end else begin
      fire_o <= 1'b0;
      unique case (st_q)
        ST_ARMED: begin
          if (sense_s_i && vcc_ok_s_i) begin
            if (cnt_q == LAST) begin
              fire_o <= 1'b1;
              st_q   <= ST_SPENT;
              cnt_q  <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end else begin
            cnt_q <= '0;
          end
        end
        ST_SPENT: begin
          if (!sense_s_i) begin
            if (cnt_q == LAST) begin
              st_q  <= ST_ARMED;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end else begin
            cnt_q <= '0;
          end
        end
        default: st_q <= ST_ARMED;
      endcase
    end
  end

  // R2
  qual_sense_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> $past(sense_s_i));

  // R7
  qual_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> $past(vcc_ok_s_i));

  // R6
  rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ARMED && $past(st_q) == ST_SPENT) |-> $past(!sense_s_i));

  // R5
  single_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o);
endmodule

// File: rtl/pfw_stretch.sv
module pfw_stretch #(
  parameter int PULSE_CYC = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic nmi_no
);
  localparam int PW = $clog2(PULSE_CYC + 1);

  logic [PW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              left_q <= '0;
    else if (fire_i)          left_q <= PW'(PULSE_CYC);
    else if (left_q != '0)    left_q <= left_q - 1'b1;
  end

  assign nmi_no = (left_q == '0);

  // R3
  fall_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(nmi_no) |-> $past(fire_i));

  // R4
  end_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nmi_no) |-> !$past(fire_i));
endmodule

// File: rtl/pfw_pulser.sv
module pfw_pulser #(
  parameter int FILT_CYC  = 5,
  parameter int PULSE_CYC = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sense_low_i,
  input  logic vcc_ok_i,
  output logic nmi_no
);
  logic [1:0] sync_q;
  logic       fire;

  pfw_sync #(.WIDTH(2), .STAGES(2)) sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({vcc_ok_i, sense_low_i}),
    .q_o    (sync_q)
  );

  pfw_qualifier #(.FILT_CYC(FILT_CYC)) qual_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sense_s_i  (sync_q[0]),
    .vcc_ok_s_i (sync_q[1]),
    .fire_o     (fire)
  );

  pfw_stretch #(.PULSE_CYC(PULSE_CYC)) stretch_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire),
    .nmi_no (nmi_no)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk_i)
    !rst_ni |-> nmi_no);
endmodule

// File: tb/pfw_pulser_tb.sv
module pfw_pulser_tb_top;
  localparam int F = 3;
  localparam int P = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sense = 1'b0;
  logic vcc = 1'b1;
  logic nmi_n;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int first_low, low_cnt, falls;

  always #5 clk = ~clk;

  pfw_pulser #(.FILT_CYC(F), .PULSE_CYC(P)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sense_low_i(sense),
    .vcc_ok_i(vcc), .nmi_no(nmi_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // hi_len: sense high for sampled edges 1..hi_len; vdrop/vrise: index at which vcc changes (-1 never)
  task automatic run_window(input int hi_len, input int vdrop, input int vrise, input int w);
    bit prev;
    first_low = 0; low_cnt = 0; falls = 0;
    prev = nmi_n;
    sense = (hi_len > 0);
    if (vrise == 0) vcc = 1'b1;
    for (int j = 1; j <= w; j++) begin
      @(posedge clk); @(negedge clk);
      if (!nmi_n) begin
        low_cnt++;
        if (first_low == 0) first_low = j;
        if (prev) falls++;
      end
      prev = nmi_n;
      if (j == hi_len) sense = 1'b0;
      if (j == vdrop) vcc = 1'b0;
      if (j == vrise) vcc = 1'b1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    @(negedge clk);
    chk(nmi_n === 1'b1, "R1 in reset", nmi_n, 1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(nmi_n === 1'b1, "R1 after reset", nmi_n, 1);

    // R2 R3 R4 sweep of high-run length
    for (int l = 1; l <= F + 3; l++) begin
      run_window(l, -1, -1, l + F + P + 8);
      if (l >= F) begin
        chk(first_low == F + 3, "R3 latency", first_low, F + 3);
        chk(low_cnt == P, "R4 width", low_cnt, P);
        chk(falls == 1, "R2 one pulse", falls, 1);
      end else begin
        chk(low_cnt == 0, "R2 glitch filtered", low_cnt, 0);
      end
    end

    // R5 sustained low
    run_window(1000, -1, -1, 3 * P + F + 10);
    chk(falls == 1, "R5 single pulse", falls, 1);
    chk(low_cnt == P, "R5 width", low_cnt, P);

    // R6 short gap does not re-arm
    sense = 1'b0;
    repeat (F - 1) @(negedge clk);
    run_window(1000, -1, -1, 2 * F + P + 10);
    chk(low_cnt == 0, "R6 no rearm", low_cnt, 0);
    run_window(0, -1, -1, F + 4);
    run_window(F + 1, -1, -1, F + P + 8);
    chk(falls == 1, "R6 rearmed", falls, 1);
    chk(first_low == F + 3, "R6 latency", first_low, F + 3);

    // R7 suppression while local supply low
    vcc = 1'b0;
    run_window(0, -1, -1, 4);
    run_window(1000, -1, -1, F + P + 10);
    chk(low_cnt == 0, "R7 suppressed", low_cnt, 0);
    run_window(1000, -1, 0, F + P + 8);
    chk(first_low == F + 3, "R7 latency after rise", first_low, F + 3);
    chk(low_cnt == P, "R7 width", low_cnt, P);
    run_window(0, -1, -1, F + 4);

    // R8 supply drop mid-pulse
    run_window(F + 2, F + 4, -1, F + P + 8);
    chk(low_cnt == P, "R8 full width", low_cnt, P);
    chk(first_low == F + 3, "R8 latency", first_low, F + 3);
    vcc = 1'b1;
    run_window(0, -1, -1, F + 4);

    // R1 async reset mid-pulse
    run_window(F + 2, -1, -1, F + 5);
    chk(nmi_n === 1'b0, "R1 pulse active", nmi_n, 0);
    rst_n = 1'b0;
    #1;
    chk(nmi_n === 1'b1, "R1 async clear", nmi_n, 1);
    @(negedge clk); rst_n = 1'b1;

    summary();
  end
endmodule